// File: doc/BRIEF.md
# Port Input Change Detector with Read-Deferred Interrupt

This block watches a small group of general-purpose input pins. It compares them against a stored snapshot. Whenever a pin differs from its snapshot value, the block sets a sticky per-pin change flag. It also drives an active-low interrupt line, so a host can learn that something changed without polling.

A serial bus front end sits beside the block and feeds it three qualifiers:
- a one-cycle strobe at the acknowledge slot of each access addressed to this device;
- a level that is high while a read transfer is in progress;
- a one-cycle strobe when the bus STOP condition is seen.

Each acknowledge strobe loads the live pins into the snapshot, clears the flags and releases the interrupt. In a long read the front end issues one such strobe per byte pair, so the pins are resampled continuously.

While a read is in progress the interrupt line is never driven active. A change seen during the read is remembered as pending. At STOP, the interrupt fires only if that change was not already captured by a later acknowledge strobe. In this way no change is lost, and no change that was already read triggers a redundant interrupt.

Top module: `pin_change_watch`

## Requirements
- R1: While reset is active and right after it, `chg_flags_o` is all zero, `snap_o` equals the parameter `RST_SNAP` (default all ones), and `irq_n_o` is 1.
- R2: With no acknowledge strobe, any bit where `pins_i` differs from `snap_o` sets the matching `chg_flags_o` bit on the next clock edge. A set flag stays set, even if the pin returns to its snapshot value, until an acknowledge strobe.
- R3: With no read in progress and no acknowledge strobe, a mismatch between `pins_i` and `snap_o` drives `irq_n_o` to 0 on the next clock edge. It stays 0 until an acknowledge strobe.
- R4: One cycle after `ack_stb_i` is high, `snap_o` equals the `pins_i` value sampled with the strobe, `chg_flags_o` is zero and `irq_n_o` is 1.
- R5: While `rd_busy_i` is high and no STOP strobe is present, `irq_n_o` never goes from 1 to 0.
- R6: A mismatch seen while `rd_busy_i` is high, with no acknowledge strobe after it before STOP, drives `irq_n_o` to 0 one cycle after `stop_stb_i`. If no mismatch occurred, `irq_n_o` stays 1 after STOP.
- R7: A change seen during a read that a later acknowledge strobe captures before STOP does not assert `irq_n_o` at STOP.
- R8: Change flags are set during reads exactly as outside them; only the interrupt is deferred.
- R9: A pin change in the same cycle as an acknowledge strobe is taken into the snapshot. It raises neither a flag nor the interrupt afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | N | Synchronized pin levels being watched |
| ack_stb_i | input | 1 | One-cycle strobe at the acknowledge slot of an access to this device |
| rd_busy_i | input | 1 | High while a read transfer is in progress |
| stop_stb_i | input | 1 | One-cycle strobe on bus STOP |
| chg_flags_o | output | N | Sticky per-pin change flags |
| snap_o | output | N | Current snapshot of the pins |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
Every result of this block is registered once, so flags, snapshot and interrupt are all due on the first clock edge after the stimulus or strobe that causes them. The bench drives pins and strobes on the falling edge and samples the outputs on the following falling edge, which is exactly one rising edge later. Strobes are held for a single cycle. The sweeps run every snapshot value against every pin pattern, both outside reads and inside reads (with and without a capturing acknowledge before STOP). The expected flags are taken as the XOR of the pattern and the snapshot.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
    typedef struct packed {
        logic snap;
        logic flag;
    } lane_st_t;

    typedef struct packed {
        logic pend;
        logic irq_n;
    } irq_st_t;
endpackage

// File: rtl/pcw_lane.sv
module pcw_lane
    import pcw_pkg::*;
#(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic ack_stb_i,
    output logic snap_o,
    output logic flag_o,
    output logic diff_o
);
    lane_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        diff_o = pin_i ^ st_q.snap;
        if (ack_stb_i) begin
            st_d.snap = pin_i;
            st_d.flag = 1'b0;
        end else if (diff_o) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.snap <= RST_VAL;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign snap_o = st_q.snap;
    assign flag_o = st_q.flag;
endmodule

// File: rtl/pcw_irq.sv
module pcw_irq
    import pcw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_diff_i,
    input  logic ack_stb_i,
    input  logic rd_busy_i,
    input  logic stop_stb_i,
    output logic irq_n_o
);
    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ack_stb_i) begin
            // capture point: everything seen so far is now read out
            st_d.pend  = 1'b0;
            st_d.irq_n = 1'b1;
        end else if (stop_stb_i) begin
            // release a change held back during the read
            if (st_q.pend || any_diff_i) st_d.irq_n = 1'b0;
            st_d.pend = 1'b0;
        end else if (rd_busy_i) begin
            if (any_diff_i) st_d.pend = 1'b1;
        end else if (any_diff_i) begin
            st_d.irq_n = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend  <= 1'b0;
            st_q.irq_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n_o = st_q.irq_n;
endmodule

// File: rtl/pin_change_watch.sv
module pin_change_watch #(
    parameter int          N        = 4,
    parameter logic [N-1:0] RST_SNAP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_i,
    input  logic         ack_stb_i,
    input  logic         rd_busy_i,
    input  logic         stop_stb_i,
    output logic [N-1:0] chg_flags_o,
    output logic [N-1:0] snap_o,
    output logic         irq_n_o
);
    logic [N-1:0] diff;

    for (genvar i = 0; i < N; i++) begin : g_lane
        pcw_lane #(.RST_VAL(RST_SNAP[i])) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_i     (pins_i[i]),
            .ack_stb_i (ack_stb_i),
            .snap_o    (snap_o[i]),
            .flag_o    (chg_flags_o[i]),
            .diff_o    (diff[i])
        );
    end

    pcw_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_diff_i (|diff),
        .ack_stb_i  (ack_stb_i),
        .rd_busy_i  (rd_busy_i),
        .stop_stb_i (stop_stb_i),
        .irq_n_o    (irq_n_o)
    );
endmodule

// File: rtl/pcw_chk.sv
module pcw_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] pins_i,
    input logic         ack_stb_i,
    input logic         rd_busy_i,
    input logic         stop_stb_i,
    input logic [N-1:0] chg_flags_o,
    input logic [N-1:0] snap_o,
    input logic         irq_n_o
);
    // R2
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_stb_i |=> ((chg_flags_o & $past(pins_i ^ snap_o)) == $past(pins_i ^ snap_o)));

    // R2
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_stb_i |=> ((chg_flags_o & $past(chg_flags_o)) == $past(chg_flags_o)));

    // R3
    irq_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_stb_i && !rd_busy_i && (pins_i != snap_o)) |=> !irq_n_o);

    // R3
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_stb_i && !irq_n_o) |=> !irq_n_o);

    // R4
    ack_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_stb_i |=> (chg_flags_o == '0 && irq_n_o && snap_o == $past(pins_i)));

    // R5
    read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy_i && !stop_stb_i && irq_n_o) |=> irq_n_o);
endmodule

bind pin_change_watch pcw_chk #(.N(N)) u_pcw_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pins_i      (pins_i),
    .ack_stb_i   (ack_stb_i),
    .rd_busy_i   (rd_busy_i),
    .stop_stb_i  (stop_stb_i),
    .chg_flags_o (chg_flags_o),
    .snap_o      (snap_o),
    .irq_n_o     (irq_n_o)
);

// File: tb/pin_change_watch_test.sv
module pin_change_watch_test;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] pins;
    logic         ack, rd_busy, stop;
    logic [N-1:0] flags, snap;
    logic         irq_n;
    int           n_chk = 0;
    int           n_fail = 0;

    always #2 clk = ~clk;

    pin_change_watch #(.N(N), .RST_SNAP(4'hF)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pins_i      (pins),
        .ack_stb_i   (ack),
        .rd_busy_i   (rd_busy),
        .stop_stb_i  (stop),
        .chg_flags_o (flags),
        .snap_o      (snap),
        .irq_n_o     (irq_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic capture(input logic [N-1:0] v);
        pins = v; ack = 1'b1; step(); ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pins = 4'hF; ack = 0; rd_busy = 0; stop = 0;
        repeat (3) step();
        chk("R1 flags in reset", 8'(flags), 8'h0);
        chk("R1 snap in reset", 8'(snap), 8'hF);
        chk("R1 irq in reset", 8'(irq_n), 8'h1);
        rst_n = 1'b1;
        step();
        chk("R1 flags after reset", 8'(flags), 8'h0);
        chk("R1 irq after reset", 8'(irq_n), 8'h1);

        // Outside reads: every snapshot against every pattern
        for (int b = 0; b < 16; b++) begin
            for (int p = 0; p < 16; p++) begin
                logic [N-1:0] d;
                d = 4'(b) ^ 4'(p);
                capture(4'(b));
                chk("R4 snap after ack", 8'(snap), 8'(b));
                chk("R4 flags after ack", 8'(flags), 8'h0);
                chk("R4 irq after ack", 8'(irq_n), 8'h1);
                pins = 4'(p); step();
                chk("R2 flags set", 8'(flags), 8'(d));
                chk("R3 irq on change", 8'(irq_n), 8'(d == 0));
                pins = 4'(b); step();
                chk("R2 flags sticky", 8'(flags), 8'(d));
                chk("R3 irq held", 8'(irq_n), 8'(d == 0));
            end
        end

        // Inside reads, with and without a capturing ack before STOP
        for (int b = 0; b < 16; b++) begin
            for (int p = 0; p < 16; p++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [N-1:0] d;
                    d = 4'(b) ^ 4'(p);
                    capture(4'(b));
                    rd_busy = 1'b1; pins = 4'(p); step();
                    chk("R5 irq quiet in read", 8'(irq_n), 8'h1);
                    chk("R8 flags in read", 8'(flags), 8'(d));
                    if (c == 1) begin
                        ack = 1'b1; step(); ack = 1'b0;
                        chk("R7 snap captured", 8'(snap), 8'(p));
                        chk("R7 flags cleared", 8'(flags), 8'h0);
                    end
                    step();
                    chk("R5 irq still quiet", 8'(irq_n), 8'h1);
                    rd_busy = 1'b0; stop = 1'b1; step(); stop = 1'b0;
                    if (c == 1) chk("R7 no irq at stop", 8'(irq_n), 8'h1);
                    else        chk("R6 irq at stop", 8'(irq_n), 8'(d == 0));
                end
            end
        end

        // Change coinciding with the ack strobe
        for (int p = 0; p < 16; p++) begin
            capture(4'(15 - p));
            pins = 4'(p); ack = 1'b1; step(); ack = 1'b0;
            chk("R9 snap takes change", 8'(snap), 8'(p));
            step();
            chk("R9 no flag", 8'(flags), 8'h0);
            chk("R9 no irq", 8'(irq_n), 8'h1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule